// File: doc/BRIEF.md
# Translation Table Walker

This block turns a 64-bit logical address into a real address by walking a chain of in-memory translation tables. A request carries the logical address, the access kind (load, store or instruction fetch) and a 64-bit address-space control word. The control word names the table level where the walk starts, the origin of that table and how long it is. The walker then fetches one 8-byte entry per level over a simple memory read port. The levels are up to three region levels, then a segment level, then a page level. It checks each entry and narrows the write and execute rights as it goes.

A walk ends in one of four ways: at a page entry, at a large-frame segment entry, at a large-frame region-third entry, or at the first fault. The result is reported for one cycle. On success it carries the real address and the surviving rights. On failure it carries an 8-bit exception code, with the address and rights forced to zero. Three enable inputs are sampled when a request is accepted. They select segment large frames with region protection, region-third large frames, and execute protection.

Logical address layout: bits [63:53] region-first index, [52:42] region-second index, [41:31] region-third index, [30:20] segment index, [19:12] page index, [11:0] byte offset. The length field of each 11-bit index is its top 2 bits. Access codes: 0 load, 1 store, 2 fetch.

Top module: `xlat_walker`

## Requirements
- R1: When control-word bit 5 (real space) is set, the result appears in the cycle after acceptance with code 0x00, address equal to the logical address, both rights set, and no memory read.
- R2: Control-word bits [3:2] select the start level: 3 region-first, 2 region-second, 1 region-third, 0 segment. Any nonzero index of a level above the start level gives code 0x38 without a read.
- R3: If the length field of the start-level index exceeds control-word bits [1:0], the start level's code is raised without a read. The codes are 0x39 region-first, 0x3A region-second, 0x3B region-third and 0x10 segment.
- R4: Each level reads exactly one entry, at table origin plus index times 8, as a one-cycle read pulse. Region table origins come from bits [63:12] of the control word or the region entry; the page table origin comes from segment entry bits [63:11]. A read error gives 0x05.
- R5: An entry's invalid bit raises that level's code: bit 5 for region and segment entries, bit 10 for page entries, with 0x11 for the page level.
- R6: If the type field [3:2] of a region or segment entry differs from the level (3 region-first, 2 region-second, 1 region-third, 0 segment), the code is 0x12.
- R7: In a region entry, the next level's index length field must lie between the offset field [7:6] and the length field [1:0], bounds included. Otherwise the next level's code is raised.
- R8: Protection bit 9 clears write rights in segment and page entries always, and in region entries only when cfg_large_seg is set.
- R9: A segment entry with bit 10 set and cfg_large_seg set ends the walk with address {entry[63:20], logical[19:0]}. A region-third entry with bit 10 set and cfg_large_reg set ends it with {entry[63:31], logical[30:0]}. Without the enable, the walk continues below.
- R10: Common bit 4 with control-word private bit 8 gives 0x12. This applies to a segment entry always, and to a region-third entry when cfg_large_reg is set.
- R11: A page entry with reserved bit 11 set gives 0x12. A valid page entry yields {entry[63:12], logical[11:0]}.
- R12: Execute-protection bit 8 of a page entry or a large-frame entry clears execute rights only when cfg_xprot is set.
- R13: A store ending without write rights, or a fetch ending without execute rights, gives 0x04. Every nonzero code is reported with address 0 and both rights cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_laddr | input | 64 | Logical address |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_asce | input | 64 | Address-space control word |
| cfg_large_seg | input | 1 | Segment large frames and region protection enable |
| cfg_large_reg | input | 1 | Region-third large frames and common-region check enable |
| cfg_xprot | input | 1 | Execute-protection enable |
| mem_rd_valid | output | 1 | One-cycle read request |
| mem_rd_addr | output | 64 | Entry address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry value |
| mem_rsp_err | input | 1 | Read failed |
| done_valid | output | 1 | Result valid for one cycle |
| done_exc | output | 8 | Exception code, 0x00 on success |
| done_raddr | output | 64 | Real address |
| done_wr_ok | output | 1 | Write permitted |
| done_ex_ok | output | 1 | Execute permitted |

## Verification
A wrong level register or pointer shows at the ports as a read to an unexpected address. It then shows as an exception code or real address that differs on the very next result, so each case compares the code, address, rights and number of reads of its walk. Rights that leak from one walk into the next show as a wrong rights bit on the next successful result. Faults whose checks are ordered wrongly show as the code of a different level, which is why many single-bit entry variants are aimed at the same path.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W   = 64;
  localparam int IDX_W  = 11;
  localparam int PX_W   = 8;
  localparam int OFF_W  = 12;
  localparam int NLVL   = 5;
  localparam int EXC_W  = 8;

  typedef enum logic [2:0] {
    LV_PAGE = 3'd0, LV_SEG = 3'd1, LV_R3 = 3'd2, LV_R2 = 3'd3, LV_R1 = 3'd4
  } lvl_t;

  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam logic [EXC_W-1:0] EXC_NONE = 8'h00;
  localparam logic [EXC_W-1:0] EXC_PROT = 8'h04;
  localparam logic [EXC_W-1:0] EXC_ADDR = 8'h05;
  localparam logic [EXC_W-1:0] EXC_SEG  = 8'h10;
  localparam logic [EXC_W-1:0] EXC_PAGE = 8'h11;
  localparam logic [EXC_W-1:0] EXC_SPEC = 8'h12;
  localparam logic [EXC_W-1:0] EXC_TYPE = 8'h38;
  localparam logic [EXC_W-1:0] EXC_R1   = 8'h39;
  localparam logic [EXC_W-1:0] EXC_R2   = 8'h3A;
  localparam logic [EXC_W-1:0] EXC_R3   = 8'h3B;

  function automatic logic [EXC_W-1:0] lvl_exc(lvl_t l);
    case (l)
      LV_R1:   return EXC_R1;
      LV_R2:   return EXC_R2;
      LV_R3:   return EXC_R3;
      LV_SEG:  return EXC_SEG;
      default: return EXC_PAGE;
    endcase
  endfunction

  function automatic logic [1:0] tt_of(lvl_t l);
    case (l)
      LV_R1:   return 2'd3;
      LV_R2:   return 2'd2;
      LV_R3:   return 2'd1;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/xlat_field.sv
module xlat_field
  import xlat_pkg::*;
(
  input  logic [VA_W-1:0]                 laddr,
  output logic [NLVL-1:0][IDX_W-1:0]      idx
);
  assign idx[0] = {{(IDX_W-PX_W){1'b0}}, laddr[OFF_W +: PX_W]};
  for (genvar g = 1; g < NLVL; g++) begin : g_lvl
    assign idx[g] = laddr[OFF_W + PX_W + IDX_W*(g-1) +: IDX_W];
  end
endmodule

// File: rtl/xlat_start.sv
module xlat_start
  import xlat_pkg::*;
(
  input  logic [VA_W-1:0]             asce,
  input  logic [NLVL-1:0][IDX_W-1:0]  idx,
  output lvl_t                        lvl,
  output logic                        fault,
  output logic [EXC_W-1:0]            exc,
  output logic [VA_W-1:0]             ptr
);
  logic high_set;
  logic [IDX_W-1:0] sidx;

  assign lvl  = lvl_t'({1'b0, asce[3:2]} + 3'd1);
  assign sidx = idx[lvl];

  always_comb begin
    high_set = 1'b0;
    for (int g = 1; g < NLVL; g++)
      if (g > int'(lvl) && idx[g] != '0) high_set = 1'b1;
  end

  always_comb begin
    fault = 1'b0;
    exc   = EXC_NONE;
    if (high_set) begin
      fault = 1'b1;
      exc   = EXC_TYPE;
    end else if (sidx[IDX_W-1 -: 2] > asce[1:0]) begin
      fault = 1'b1;
      exc   = lvl_exc(lvl);
    end
  end

  assign ptr = {asce[VA_W-1:OFF_W], {OFF_W{1'b0}}} + VA_W'({sidx, 3'b000});
endmodule

// File: rtl/xlat_entry.sv
module xlat_entry
  import xlat_pkg::*;
(
  input  lvl_t                        lvl,
  input  logic [VA_W-1:0]             ent,
  input  logic [VA_W-1:0]             laddr,
  input  logic [NLVL-1:0][IDX_W-1:0]  idx,
  input  logic                        priv,
  input  logic                        large_seg,
  input  logic                        large_reg,
  input  logic                        xprot,
  output logic                        fault,
  output logic [EXC_W-1:0]            exc,
  output logic                        clr_wr,
  output logic                        clr_ex,
  output logic                        term,
  output logic [VA_W-1:0]             next_ptr,
  output logic [VA_W-1:0]             frame
);
  lvl_t nl;
  logic [IDX_W-1:0] nidx;
  logic [1:0] nlen;

  assign nl   = lvl_t'(lvl - 3'd1);
  assign nidx = idx[nl];
  assign nlen = nidx[IDX_W-1 -: 2];

  always_comb begin
    fault    = 1'b0;
    exc      = EXC_NONE;
    clr_wr   = 1'b0;
    clr_ex   = 1'b0;
    term     = 1'b0;
    next_ptr = '0;
    frame    = '0;
    case (lvl)
      LV_R1, LV_R2, LV_R3: begin
        if (ent[5]) begin
          fault = 1'b1; exc = lvl_exc(lvl);
        end else if (ent[3:2] != tt_of(lvl)) begin
          fault = 1'b1; exc = EXC_SPEC;
        end else if (lvl == LV_R3 && large_reg && ent[4] && priv) begin
          fault = 1'b1; exc = EXC_SPEC;
        end else begin
          clr_wr = large_seg & ent[9];
          if (lvl == LV_R3 && large_reg && ent[10]) begin
            term   = 1'b1;
            clr_ex = xprot & ent[8];
            frame  = {ent[VA_W-1:31], laddr[30:0]};
          end else if (nlen < ent[7:6] || nlen > ent[1:0]) begin
            fault = 1'b1; exc = lvl_exc(nl);
          end else begin
            next_ptr = {ent[VA_W-1:OFF_W], {OFF_W{1'b0}}} + VA_W'({nidx, 3'b000});
          end
        end
      end
      LV_SEG: begin
        if (ent[5]) begin
          fault = 1'b1; exc = EXC_SEG;
        end else if (ent[3:2] != 2'd0 || (ent[4] && priv)) begin
          fault = 1'b1; exc = EXC_SPEC;
        end else begin
          clr_wr = ent[9];
          if (large_seg && ent[10]) begin
            term   = 1'b1;
            clr_ex = xprot & ent[8];
            frame  = {ent[VA_W-1:20], laddr[19:0]};
          end else begin
            next_ptr = {ent[VA_W-1:11], 11'b0} + VA_W'({idx[0], 3'b000});
          end
        end
      end
      default: begin
        if (ent[10]) begin
          fault = 1'b1; exc = EXC_PAGE;
        end else if (ent[11]) begin
          fault = 1'b1; exc = EXC_SPEC;
        end else begin
          clr_wr = ent[9];
          clr_ex = xprot & ent[8];
          term   = 1'b1;
          frame  = {ent[VA_W-1:OFF_W], laddr[OFF_W-1:0]};
        end
      end
    endcase
  end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_laddr,
  input  logic [1:0]        req_acc,
  input  logic [63:0]       req_asce,
  input  logic              cfg_large_seg,
  input  logic              cfg_large_reg,
  input  logic              cfg_xprot,
  output logic              mem_rd_valid,
  output logic [63:0]       mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              done_valid,
  output logic [7:0]        done_exc,
  output logic [63:0]       done_raddr,
  output logic              done_wr_ok,
  output logic              done_ex_ok
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;

  st_t st_q, st_d;
  lvl_t lvl_q, lvl_d;
  logic [VA_W-1:0] ptr_q, ptr_d, la_q, la_d;
  logic [1:0] acc_q, acc_d;
  logic priv_q, priv_d, wr_q, wr_d, ex_q, ex_d;
  logic l1_q, l1_d, l2_q, l2_d, xp_q, xp_d;

  logic fin, f_wr, f_ex, nwr, nex;
  logic [EXC_W-1:0] f_exc;
  logic [VA_W-1:0] f_addr;

  logic [NLVL-1:0][IDX_W-1:0] idx_in, idx_q;
  lvl_t st_lvl;
  logic st_fault;
  logic [EXC_W-1:0] st_exc;
  logic [VA_W-1:0] st_ptr;

  logic e_fault, e_clr_wr, e_clr_ex, e_term;
  logic [EXC_W-1:0] e_exc;
  logic [VA_W-1:0] e_next, e_frame;

  xlat_field u_fld_in (.laddr(req_laddr), .idx(idx_in));
  xlat_field u_fld_q  (.laddr(la_q),      .idx(idx_q));

  xlat_start u_start (
    .asce(req_asce), .idx(idx_in), .lvl(st_lvl),
    .fault(st_fault), .exc(st_exc), .ptr(st_ptr)
  );

  xlat_entry u_ent (
    .lvl(lvl_q), .ent(mem_rsp_data), .laddr(la_q), .idx(idx_q),
    .priv(priv_q), .large_seg(l1_q), .large_reg(l2_q), .xprot(xp_q),
    .fault(e_fault), .exc(e_exc), .clr_wr(e_clr_wr), .clr_ex(e_clr_ex),
    .term(e_term), .next_ptr(e_next), .frame(e_frame)
  );

  assign req_ready    = (st_q == S_IDLE);
  assign mem_rd_valid = (st_q == S_REQ);
  assign mem_rd_addr  = ptr_q;
  assign nwr          = wr_q & ~e_clr_wr;
  assign nex          = ex_q & ~e_clr_ex;

  always_comb begin
    st_d = st_q;  lvl_d = lvl_q; ptr_d = ptr_q; la_d = la_q;
    acc_d = acc_q; priv_d = priv_q; wr_d = wr_q; ex_d = ex_q;
    l1_d = l1_q; l2_d = l2_q; xp_d = xp_q;
    fin = 1'b0; f_exc = EXC_NONE; f_addr = '0; f_wr = 1'b0; f_ex = 1'b0;
    case (st_q)
      S_IDLE: if (req_valid) begin
        la_d = req_laddr; acc_d = req_acc; priv_d = req_asce[8];
        wr_d = 1'b1; ex_d = 1'b1;
        l1_d = cfg_large_seg; l2_d = cfg_large_reg; xp_d = cfg_xprot;
        if (req_asce[5]) begin
          fin = 1'b1; f_addr = req_laddr; f_wr = 1'b1; f_ex = 1'b1;
        end else if (st_fault) begin
          fin = 1'b1; f_exc = st_exc;
        end else begin
          lvl_d = st_lvl; ptr_d = st_ptr; st_d = S_REQ;
        end
      end
      S_REQ: st_d = S_WAIT;
      default: if (mem_rsp_valid) begin
        if (mem_rsp_err) begin
          fin = 1'b1; f_exc = EXC_ADDR;
        end else if (e_fault) begin
          fin = 1'b1; f_exc = e_exc;
        end else if (e_term) begin
          fin = 1'b1;
          if ((acc_q == ACC_STORE && !nwr) || (acc_q == ACC_FETCH && !nex))
            f_exc = EXC_PROT;
          else begin
            f_addr = e_frame; f_wr = nwr; f_ex = nex;
          end
        end else begin
          wr_d = nwr; ex_d = nex;
          lvl_d = lvl_t'(lvl_q - 3'd1); ptr_d = e_next; st_d = S_REQ;
        end
      end
    endcase
    if (fin) st_d = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= S_IDLE; lvl_q <= LV_PAGE; ptr_q <= '0; la_q <= '0;
      acc_q <= '0; priv_q <= 1'b0; wr_q <= 1'b0; ex_q <= 1'b0;
      l1_q <= 1'b0; l2_q <= 1'b0; xp_q <= 1'b0;
      done_valid <= 1'b0; done_exc <= EXC_NONE; done_raddr <= '0;
      done_wr_ok <= 1'b0; done_ex_ok <= 1'b0;
    end else begin
      st_q <= st_d; lvl_q <= lvl_d; ptr_q <= ptr_d; la_q <= la_d;
      acc_q <= acc_d; priv_q <= priv_d; wr_q <= wr_d; ex_q <= ex_d;
      l1_q <= l1_d; l2_q <= l2_d; xp_q <= xp_d;
      done_valid <= fin;
      if (fin) begin
        done_exc <= f_exc; done_raddr <= f_addr;
        done_wr_ok <= f_wr; done_ex_ok <= f_ex;
      end
    end
  end
endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic [63:0] req_laddr,
  input logic [1:0]  req_acc,
  input logic [63:0] req_asce,
  input logic        cfg_large_seg,
  input logic        cfg_large_reg,
  input logic        cfg_xprot,
  input logic        mem_rd_valid,
  input logic [63:0] mem_rd_addr,
  input logic        mem_rsp_valid,
  input logic [63:0] mem_rsp_data,
  input logic        mem_rsp_err,
  input logic        done_valid,
  input logic [7:0]  done_exc,
  input logic [63:0] done_raddr,
  input logic        done_wr_ok,
  input logic        done_ex_ok
);
  logic [1:0] acc_seen;

  always_ff @(posedge clk) begin
    if (rst) acc_seen <= 2'd0;
    else if (req_valid && req_ready) acc_seen <= req_acc;
  end

  p_real_bypass_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_asce[5]) |=>
      (done_valid && done_exc == 8'h00 && done_raddr == $past(req_laddr) && !mem_rd_valid))
    else $error("real-space bypass result wrong");

  p_pulse_read_r4: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |=> !mem_rd_valid)
    else $error("read request longer than one cycle");

  p_aligned_read_r4: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |-> (mem_rd_addr[2:0] == 3'b000 && !req_ready))
    else $error("read misaligned or issued while idle");

  p_store_rights_r13: assert property (@(posedge clk) disable iff (rst)
    (done_valid && done_exc == 8'h00 && acc_seen == 2'd1) |-> done_wr_ok)
    else $error("store completed without write rights");

  p_fetch_rights_r13: assert property (@(posedge clk) disable iff (rst)
    (done_valid && done_exc == 8'h00 && acc_seen == 2'd2) |-> done_ex_ok)
    else $error("fetch completed without execute rights");

  p_fault_clean_r13: assert property (@(posedge clk) disable iff (rst)
    (done_valid && done_exc != 8'h00) |-> (done_raddr == 64'd0 && !done_wr_ok && !done_ex_ok))
    else $error("fault result carries address or rights");
endmodule

bind xlat_walker xlat_walker_chk u_chk (.*);

// File: tb/sim_xlat_walker.sv
module sim_xlat_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_laddr = '0;
  logic [1:0]  req_acc = '0;
  logic [63:0] req_asce = '0;
  logic        cfg_large_seg = 1'b0, cfg_large_reg = 1'b0, cfg_xprot = 1'b0;
  logic        mem_rd_valid;
  logic [63:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        mem_rsp_err = 1'b0;
  logic        done_valid;
  logic [7:0]  done_exc;
  logic [63:0] done_raddr;
  logic        done_wr_ok, done_ex_ok;

  int checks = 0, errors = 0, rd_cnt = 0, rd_base = 0;
  bit finished = 0;
  logic [63:0] mem [logic [63:0]];

  logic [7:0]  q_exc [$];
  logic [63:0] q_ra  [$];
  logic        q_wr  [$];
  logic        q_ex  [$];
  int          q_rd  [$];
  string       q_tag [$];

  always #10 clk = ~clk;

  xlat_walker u0 (.*);

  always @(posedge clk) begin
    mem_rsp_valid <= mem_rd_valid;
    mem_rsp_err   <= mem_rd_addr[40];
    mem_rsp_data  <= mem.exists(mem_rd_addr) ? mem[mem_rd_addr] : 64'd0;
  end

  always @(negedge clk) if (!rst && mem_rd_valid) rd_cnt++;

  always @(negedge clk) begin
    if (!rst && done_valid) begin
      checks++;
      if (q_exc.size() == 0) begin
        errors++;
        $display("FAIL unexpected result: exc %h raddr %h (expected none)", done_exc, done_raddr);
      end else begin
        logic [7:0] e; logic [63:0] a; logic w, x; int r; string t;
        e = q_exc.pop_front(); a = q_ra.pop_front(); w = q_wr.pop_front();
        x = q_ex.pop_front(); r = q_rd.pop_front(); t = q_tag.pop_front();
        if (done_exc !== e || done_raddr !== a || done_wr_ok !== w ||
            done_ex_ok !== x || (rd_cnt - rd_base) != r) begin
          errors++;
          $display("FAIL %s: exc/raddr/wr/ex/reads = %h/%h/%b/%b/%0d expected %h/%h/%b/%b/%0d",
                   t, done_exc, done_raddr, done_wr_ok, done_ex_ok, rd_cnt - rd_base,
                   e, a, w, x, r);
        end
      end
    end
  end

  function automatic logic [63:0] mk_la(int rf, int rs, int rt, int sx, int px, int bx);
    return {rf[10:0], rs[10:0], rt[10:0], sx[10:0], px[7:0], bx[11:0]};
  endfunction

  function automatic logic [63:0] mk_asce(logic [63:0] org, int typ, int tl, bit priv, bit rl);
    return {org[63:12], 12'h0} | (64'(priv) << 8) | (64'(rl) << 5) |
           (64'(typ[1:0]) << 2) | 64'(tl[1:0]);
  endfunction

  task automatic go(input logic [63:0] la, input logic [1:0] acc, input logic [63:0] asce,
                    input bit l1, input bit l2, input bit xp,
                    input logic [7:0] e_exc, input logic [63:0] e_ra,
                    input bit e_wr, input bit e_ex, input int e_rd, input string tag);
    @(negedge clk);
    rd_base = rd_cnt;
    q_exc.push_back(e_exc); q_ra.push_back(e_ra); q_wr.push_back(e_wr);
    q_ex.push_back(e_ex); q_rd.push_back(e_rd); q_tag.push_back(tag);
    req_laddr = la; req_acc = acc; req_asce = asce;
    cfg_large_seg = l1; cfg_large_reg = l2; cfg_xprot = xp;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (q_exc.size() != 0) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  initial begin
    logic [63:0] AS, ASP, A1, A3, A3P;
    AS  = mk_asce(64'h1000, 0, 3, 0, 0);
    ASP = mk_asce(64'h1000, 0, 3, 1, 0);
    A1  = mk_asce(64'h10000, 3, 3, 0, 0);
    A3  = mk_asce(64'h20000, 1, 3, 0, 0);
    A3P = mk_asce(64'h20000, 1, 3, 1, 0);

    mem[64'h1028] = 64'h2000;
    mem[64'h2038] = 64'hABCDE000;
    mem[64'h2040] = 64'h55000 | 64'h200;
    mem[64'h2048] = 64'h66000 | 64'h100;
    mem[64'h2050] = 64'h400;
    mem[64'h2058] = 64'h800;
    mem[64'h1030] = 64'h0000_0100_0000_0000;
    mem[64'h1038] = 64'h20;
    mem[64'h1040] = 64'h2004;
    mem[64'h1048] = 64'h2010;
    mem[64'h1050] = 64'h7770_0500;
    mem[64'h1058] = 64'h2200;
    mem[64'h10008] = 64'h1100F;
    mem[64'h11010] = 64'h1200B;
    mem[64'h12018] = 64'h13007;
    mem[64'h13020] = 64'h14000;
    mem[64'h14028] = 64'h9_8765_4000;
    mem[64'h10010] = 64'h1104F;
    mem[64'h10018] = 64'h1100C;
    mem[64'h10020] = 64'h1120F;
    mem[64'h10028] = 64'h1100B;
    mem[64'h10030] = 64'h1102F;
    mem[64'h20008] = 64'h2_8000_0407;
    mem[64'h20010] = 64'h2_8000_0417;
    mem[64'h20018] = 64'h2_8000_0507;

    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(req_ready === 1'b1, "reset ready", 64'(req_ready), 64'd1);
    chk(done_valid === 1'b0, "reset done_valid", 64'(done_valid), 64'd0);
    chk(mem_rd_valid === 1'b0, "reset mem_rd_valid", 64'(mem_rd_valid), 64'd0);
    rst = 1'b0;

    // segment start, page walks
    go(mk_la(0,0,0,5,7,'h123), 2'd0, AS, 0,0,0, 8'h00, 64'hABCDE123, 1,1, 2, "R4 R11 page load");
    go(mk_la(0,0,0,5,7,'h123), 2'd1, AS, 0,0,0, 8'h00, 64'hABCDE123, 1,1, 2, "R11 page store");
    go(mk_la(0,0,0,5,8,'h123), 2'd0, AS, 0,0,0, 8'h00, 64'h55123, 0,1, 2, "R8 page protect load");
    go(mk_la(0,0,0,5,8,'h123), 2'd1, AS, 0,0,0, 8'h04, 64'h0, 0,0, 2, "R13 page protect store");
    go(mk_la(0,0,0,5,9,'h123), 2'd2, AS, 0,0,0, 8'h00, 64'h66123, 1,1, 2, "R12 xprot off fetch");
    go(mk_la(0,0,0,5,9,'h123), 2'd2, AS, 0,0,1, 8'h04, 64'h0, 0,0, 2, "R12 xprot on fetch");
    go(mk_la(0,0,0,5,9,'h123), 2'd0, AS, 0,0,1, 8'h00, 64'h66123, 1,0, 2, "R12 xprot on load");
    go(mk_la(0,0,0,5,10,'h123), 2'd0, AS, 0,0,0, 8'h11, 64'h0, 0,0, 2, "R5 page invalid");
    go(mk_la(0,0,0,5,11,'h123), 2'd0, AS, 0,0,0, 8'h12, 64'h0, 0,0, 2, "R11 page reserved bit");
    go(mk_la(0,0,0,6,7,0), 2'd0, AS, 0,0,0, 8'h05, 64'h0, 0,0, 2, "R4 read error");
    go(mk_la(0,0,0,7,7,0), 2'd0, AS, 0,0,0, 8'h10, 64'h0, 0,0, 1, "R5 segment invalid");
    go(mk_la(0,0,0,8,7,0), 2'd0, AS, 0,0,0, 8'h12, 64'h0, 0,0, 1, "R6 segment type");
    go(mk_la(0,0,0,9,7,'h123), 2'd0, ASP, 0,0,0, 8'h12, 64'h0, 0,0, 1, "R10 common segment private");
    go(mk_la(0,0,0,9,7,'h123), 2'd0, AS, 0,0,0, 8'h00, 64'hABCDE123, 1,1, 2, "R10 common segment shared");
    go(mk_la(0,0,0,10,'h12,'h345), 2'd0, AS, 1,0,1, 8'h00, 64'h77712345, 1,0, 1, "R9 large segment");
    go(mk_la(0,0,0,10,'h12,'h345), 2'd0, AS, 0,0,1, 8'h00, 64'h345, 1,1, 2, "R9 large segment disabled");
    go(mk_la(0,0,0,11,7,'h123), 2'd0, AS, 0,0,0, 8'h00, 64'hABCDE123, 0,1, 2, "R8 segment protect");
    go(mk_la(0,0,0,'h200,0,'h10), 2'd0, mk_asce(64'h1000,0,0,0,0), 0,0,0, 8'h10, 64'h0, 0,0, 0, "R3 segment length");
    go(mk_la(0,0,0,'h200,0,'h10), 2'd0, mk_asce(64'h1000,0,1,0,0), 0,0,0, 8'h00, 64'h10, 1,1, 2, "R3 segment length at bound");
    go(mk_la(0,0,1,5,7,0), 2'd0, AS, 0,0,0, 8'h38, 64'h0, 0,0, 0, "R2 higher index set");

    // region-first start
    go(mk_la(1,2,3,4,5,'h9A), 2'd0, A1, 0,0,0, 8'h00, 64'h9_8765_409A, 1,1, 5, "R2 R4 five-level walk");
    go(mk_la(2,2,3,4,5,'h9A), 2'd0, A1, 0,0,0, 8'h3A, 64'h0, 0,0, 1, "R7 below offset");
    go(mk_la(3,'h600,3,4,5,'h9A), 2'd0, A1, 0,0,0, 8'h3A, 64'h0, 0,0, 1, "R7 above length");
    go(mk_la(4,2,3,4,5,'h9A), 2'd0, A1, 0,0,0, 8'h00, 64'h9_8765_409A, 1,1, 5, "R8 region protect disabled");
    go(mk_la(4,2,3,4,5,'h9A), 2'd0, A1, 1,0,0, 8'h00, 64'h9_8765_409A, 0,1, 5, "R8 region protect enabled");
    go(mk_la(4,2,3,4,5,'h9A), 2'd1, A1, 1,0,0, 8'h04, 64'h0, 0,0, 5, "R13 store region protect");
    go(mk_la(5,2,3,4,5,'h9A), 2'd0, A1, 0,0,0, 8'h12, 64'h0, 0,0, 1, "R6 region type");
    go(mk_la(6,2,3,4,5,'h9A), 2'd0, A1, 0,0,0, 8'h39, 64'h0, 0,0, 1, "R5 region invalid");
    go(mk_la('h200,0,0,0,0,0), 2'd0, mk_asce(64'h10000,3,0,0,0), 0,0,0, 8'h39, 64'h0, 0,0, 0, "R3 region-first length");

    // region-third start
    go(mk_la(0,0,1,3,4,'h56), 2'd0, A3, 0,1,0, 8'h00, 64'h2_8030_4056, 1,1, 1, "R9 large region");
    go(mk_la(0,0,1,3,4,'h56), 2'd0, A3, 0,0,0, 8'h00, 64'h56, 1,1, 3, "R9 large region disabled");
    go(mk_la(0,0,2,3,4,'h56), 2'd0, A3P, 0,1,0, 8'h12, 64'h0, 0,0, 1, "R10 common region private");
    go(mk_la(0,0,3,3,4,'h56), 2'd2, A3, 0,1,1, 8'h04, 64'h0, 0,0, 1, "R12 large region xprot fetch");
    go(mk_la(0,0,3,3,4,'h56), 2'd2, A3, 0,1,0, 8'h00, 64'h2_8030_4056, 1,1, 1, "R12 large region xprot off");
    go(mk_la(0,1,0,0,0,0), 2'd0, A3, 0,0,0, 8'h38, 64'h0, 0,0, 0, "R2 region-third higher index");
    go(mk_la(0,0,'h200,0,0,0), 2'd0, mk_asce(64'h20000,1,0,0,0), 0,0,0, 8'h3B, 64'h0, 0,0, 0, "R3 region-third length");
    go(mk_la(0,'h200,0,0,0,0), 2'd0, mk_asce(64'h30000,2,0,0,0), 0,0,0, 8'h3A, 64'h0, 0,0, 0, "R3 region-second length");

    // real space
    go(64'hDEAD_BEEF_0123_4567, 2'd1, mk_asce(64'h1000,0,0,0,1), 0,0,0, 8'h00, 64'hDEAD_BEEF_0123_4567, 1,1, 0, "R1 real space");

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule